// File: doc/BRIEF.md
# I2C Control Register Sequencer

This block holds the control word of an I2C peripheral and turns its request bits into one-cycle commands for the bus engine. Software writes the whole word through a simple write strobe. The bus engine feeds back events: start sent, stop detected, timeout and byte done. Those events set or clear the request bits on their own.

The start and stop requests mean different things depending on whether the engine is currently master or slave. In master mode a start request becomes a repeated-start command. A stop request is issued after the current byte, or straight after a start that is being sent. In slave mode a start request waits until the bus is free. A stop request does not drive a stop; it becomes a line-release command after the current byte.

While a request is outstanding, software writes cannot raise another one. The configuration enables are latched and presented on dedicated outputs: clock-stretch disable, general-call enable, PEC enable, ARP enable, SMBus host/device type and SMBus mode.

Top module: `i2c_ctrl_seq`

## Requirements
- R1: Bit 2 of the control word is reserved. It reads as 0 at all times, and writing 1 to it has no effect.
- R2: The configuration bits are written by software and read back unchanged on `rd_data`. Their positions are: clock-stretch disable bit 0, general-call enable bit 1, SMBus mode bit 3, SMBus host bit 4, PEC enable bit 5, ARP enable bit 6. They also appear on the matching outputs. All bits are 0 after reset.
- R3: The acknowledge-enable bit (bit 7) is written by software. It is forced to 0 in every cycle in which `periph_en` is low, and a write of 1 in such a cycle is lost.
- R4: The start request bit (bit 8) is cleared when `ev_start_sent` is high or when `periph_en` is low. A hardware clear beats a software set in the same cycle.
- R5: The stop request bit (bit 9) is cleared by `ev_stop_det` and set by `ev_timeout`. When both events occur in the same cycle, the clear wins.
- R6: While the start or stop bit is 1, writes leave bits 8 and 9 untouched. The other fields of the same write still update.
- R7: In master mode, a set start bit produces `start_pulse` in the second cycle after the write edge.
- R8: In slave mode, `start_pulse` is held back until `bus_free` is high. It is then produced one cycle after the first such cycle.
- R9: In master mode, a set stop bit produces `stop_pulse` one cycle after a cycle in which `ev_byte_done` or `ev_start_sent` is high.
- R10: In slave mode, a set stop bit produces `release_pulse` one cycle after a cycle with `ev_byte_done` high, and never produces `stop_pulse`.
- R11: Each pulse lasts one cycle and is issued once per request. No further pulse comes while the bit stays set; only a clear followed by a fresh set re-arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Software write strobe for the control word |
| wr_data | input | 10 | Control word to write |
| rd_data | output | 10 | Current control word |
| periph_en | input | 1 | Peripheral enable |
| master_mode | input | 1 | 1 while the bus engine acts as master |
| bus_free | input | 1 | 1 while no transfer is on the bus |
| ev_start_sent | input | 1 | Start condition has been sent |
| ev_stop_det | input | 1 | Stop condition detected |
| ev_timeout | input | 1 | Timeout error detected |
| ev_byte_done | input | 1 | Current byte transfer finished |
| start_pulse | output | 1 | Command: generate (repeated) start |
| stop_pulse | output | 1 | Command: generate stop (master) |
| release_pulse | output | 1 | Command: release SCL and SDA (slave) |
| cfg_ack_en | output | 1 | Acknowledge enable |
| cfg_nostretch | output | 1 | Clock stretching disabled |
| cfg_gcall_en | output | 1 | General call enable |
| cfg_pec_en | output | 1 | PEC enable |
| cfg_arp_en | output | 1 | ARP enable |
| cfg_smb_host | output | 1 | SMBus host type |
| cfg_smb_mode | output | 1 | SMBus mode |

## Verification
The assertions check the per-cycle rules on every cycle:
- the reserved bit stays at 0;
- acknowledge and start are cleared while the peripheral is disabled;
- each hardware event clears or sets its bit on the next cycle;
- a pending request survives writes;
- pulses are one cycle long, never overlap, and each follows a set request bit.

Only the bench scenarios can show the timing of each command against the mode and the events. These include the wait for a free bus in slave mode, stop after a start versus after a byte, release instead of stop in slave mode, and the fact that a request pulses just once until it is re-armed.

// File: rtl/i2c_ctrl_pkg.sv
package i2c_ctrl_pkg;

    localparam int REG_W       = 10;
    localparam int B_NOSTRETCH = 0;
    localparam int B_GCALL     = 1;
    localparam int B_RSVD      = 2;
    localparam int B_SMB_MODE  = 3;
    localparam int B_SMB_HOST  = 4;
    localparam int B_PEC_EN    = 5;
    localparam int B_ARP_EN    = 6;
    localparam int B_ACK       = 7;
    localparam int B_START     = 8;
    localparam int B_STOP      = 9;

    typedef struct packed {
        logic stop;
        logic start;
        logic ack;
        logic arp_en;
        logic pec_en;
        logic smb_host;
        logic smb_mode;
        logic gcall_en;
        logic nostretch;
    } ctrl_t;

    typedef struct packed {
        logic start_done;
        logic stop_done;
        logic start_pulse;
        logic stop_pulse;
        logic release_pulse;
    } sched_t;

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] w;
        w              = '0;
        w[B_NOSTRETCH] = c.nostretch;
        w[B_GCALL]     = c.gcall_en;
        w[B_RSVD]      = 1'b0;
        w[B_SMB_MODE]  = c.smb_mode;
        w[B_SMB_HOST]  = c.smb_host;
        w[B_PEC_EN]    = c.pec_en;
        w[B_ARP_EN]    = c.arp_en;
        w[B_ACK]       = c.ack;
        w[B_START]     = c.start;
        w[B_STOP]      = c.stop;
        return w;
    endfunction

endpackage

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs
    import i2c_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             periph_en,
    input  logic             ev_start_sent,
    input  logic             ev_stop_det,
    input  logic             ev_timeout,
    output ctrl_t            ctrl
);

    ctrl_t reg_d, reg_q;
    logic  req_locked;

    always_comb begin
        reg_d      = reg_q;
        req_locked = reg_q.start | reg_q.stop;

        // software write: request bits only when nothing is outstanding
        if (wr_en) begin
            reg_d.nostretch = wr_data[B_NOSTRETCH];
            reg_d.gcall_en  = wr_data[B_GCALL];
            reg_d.smb_mode  = wr_data[B_SMB_MODE];
            reg_d.smb_host  = wr_data[B_SMB_HOST];
            reg_d.pec_en    = wr_data[B_PEC_EN];
            reg_d.arp_en    = wr_data[B_ARP_EN];
            reg_d.ack       = wr_data[B_ACK];
            if (!req_locked) begin
                reg_d.start = wr_data[B_START];
                reg_d.stop  = wr_data[B_STOP];
            end
        end

        // hardware events, applied last so they override software
        if (ev_timeout)    reg_d.stop  = 1'b1;
        if (ev_stop_det)   reg_d.stop  = 1'b0;
        if (ev_start_sent) reg_d.start = 1'b0;
        if (!periph_en) begin
            reg_d.start = 1'b0;
            reg_d.ack   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign ctrl = reg_q;

endmodule

// File: rtl/i2c_ctrl_sched.sv
module i2c_ctrl_sched
    import i2c_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic periph_en,
    input  logic master_mode,
    input  logic bus_free,
    input  logic ev_start_sent,
    input  logic ev_byte_done,
    input  logic start_req,
    input  logic stop_req,
    output logic start_pulse,
    output logic stop_pulse,
    output logic release_pulse
);

    sched_t sch_d, sch_q;
    logic   start_fire;
    logic   stop_trig;
    logic   stop_fire;

    always_comb begin
        // master start = repeated start now; slave start waits for a free bus
        start_fire = start_req & ~sch_q.start_done & periph_en
                   & (master_mode | bus_free);
        stop_trig  = master_mode ? (ev_byte_done | ev_start_sent) : ev_byte_done;
        stop_fire  = stop_req & ~sch_q.stop_done & periph_en & stop_trig;

        sch_d               = sch_q;
        sch_d.start_done    = start_req & (sch_q.start_done | start_fire);
        sch_d.stop_done     = stop_req  & (sch_q.stop_done  | stop_fire);
        sch_d.start_pulse   = start_fire;
        sch_d.stop_pulse    = stop_fire &  master_mode;
        sch_d.release_pulse = stop_fire & ~master_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sch_q <= '0;
        else        sch_q <= sch_d;
    end

    assign start_pulse   = sch_q.start_pulse;
    assign stop_pulse    = sch_q.stop_pulse;
    assign release_pulse = sch_q.release_pulse;

endmodule

// File: rtl/i2c_ctrl_seq.sv
module i2c_ctrl_seq
    import i2c_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             periph_en,
    input  logic             master_mode,
    input  logic             bus_free,
    input  logic             ev_start_sent,
    input  logic             ev_stop_det,
    input  logic             ev_timeout,
    input  logic             ev_byte_done,
    output logic             start_pulse,
    output logic             stop_pulse,
    output logic             release_pulse,
    output logic             cfg_ack_en,
    output logic             cfg_nostretch,
    output logic             cfg_gcall_en,
    output logic             cfg_pec_en,
    output logic             cfg_arp_en,
    output logic             cfg_smb_host,
    output logic             cfg_smb_mode
);

    ctrl_t ctrl;

    i2c_ctrl_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .periph_en     (periph_en),
        .ev_start_sent (ev_start_sent),
        .ev_stop_det   (ev_stop_det),
        .ev_timeout    (ev_timeout),
        .ctrl          (ctrl)
    );

    i2c_ctrl_sched u_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .periph_en     (periph_en),
        .master_mode   (master_mode),
        .bus_free      (bus_free),
        .ev_start_sent (ev_start_sent),
        .ev_byte_done  (ev_byte_done),
        .start_req     (ctrl.start),
        .stop_req      (ctrl.stop),
        .start_pulse   (start_pulse),
        .stop_pulse    (stop_pulse),
        .release_pulse (release_pulse)
    );

    assign rd_data       = pack_ctrl(ctrl);
    assign cfg_ack_en    = ctrl.ack;
    assign cfg_nostretch = ctrl.nostretch;
    assign cfg_gcall_en  = ctrl.gcall_en;
    assign cfg_pec_en    = ctrl.pec_en;
    assign cfg_arp_en    = ctrl.arp_en;
    assign cfg_smb_host  = ctrl.smb_host;
    assign cfg_smb_mode  = ctrl.smb_mode;

endmodule

// File: rtl/i2c_ctrl_seq_chk.sv
module i2c_ctrl_seq_chk
    import i2c_ctrl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] rd_data,
    input logic             periph_en,
    input logic             ev_start_sent,
    input logic             ev_stop_det,
    input logic             ev_timeout,
    input logic             start_pulse,
    input logic             stop_pulse,
    input logic             release_pulse
);

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[B_RSVD] == 1'b0);

    assert_ack_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> !rd_data[B_ACK]);

    assert_start_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start_sent || !periph_en) |=> !rd_data[B_START]);

    assert_stop_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop_det |=> !rd_data[B_STOP]);

    assert_timeout_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_timeout && !ev_stop_det) |=> rd_data[B_STOP]);

    assert_start_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_data[B_START] && periph_en && !ev_start_sent) |=> rd_data[B_START]);

    assert_no_new_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_data[B_START] && !rd_data[B_STOP] && !ev_timeout) |=> !rd_data[B_STOP]);

    assert_start_from_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(rd_data[B_START]));

    assert_stop_vs_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_pulse && release_pulse));

    assert_start_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    assert_stop_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pulse || release_pulse) |=> !(stop_pulse || release_pulse));

endmodule

bind i2c_ctrl_seq i2c_ctrl_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .rd_data       (rd_data),
    .periph_en     (periph_en),
    .ev_start_sent (ev_start_sent),
    .ev_stop_det   (ev_stop_det),
    .ev_timeout    (ev_timeout),
    .start_pulse   (start_pulse),
    .stop_pulse    (stop_pulse),
    .release_pulse (release_pulse)
);

// File: tb/i2c_ctrl_seq_bench.sv
`timescale 1ns/1ps
module i2c_ctrl_seq_bench;

    localparam int W = 10;
    localparam logic [W-1:0] M_START = 10'h100;
    localparam logic [W-1:0] M_STOP  = 10'h200;
    localparam int SEL_RD = 0, SEL_SP = 1, SEL_PP = 2, SEL_RL = 3, SEL_CFG = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic periph_en = 1'b0, master_mode = 1'b0, bus_free = 1'b0;
    logic ev_start_sent = 1'b0, ev_stop_det = 1'b0, ev_timeout = 1'b0, ev_byte_done = 1'b0;
    logic start_pulse, stop_pulse, release_pulse;
    logic cfg_ack_en, cfg_nostretch, cfg_gcall_en, cfg_pec_en, cfg_arp_en, cfg_smb_host, cfg_smb_mode;

    always #2 clk = ~clk;

    i2c_ctrl_seq u_i2c_ctrl_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .periph_en(periph_en), .master_mode(master_mode), .bus_free(bus_free),
        .ev_start_sent(ev_start_sent), .ev_stop_det(ev_stop_det),
        .ev_timeout(ev_timeout), .ev_byte_done(ev_byte_done),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .release_pulse(release_pulse),
        .cfg_ack_en(cfg_ack_en), .cfg_nostretch(cfg_nostretch), .cfg_gcall_en(cfg_gcall_en),
        .cfg_pec_en(cfg_pec_en), .cfg_arp_en(cfg_arp_en), .cfg_smb_host(cfg_smb_host),
        .cfg_smb_mode(cfg_smb_mode)
    );

    typedef struct {
        int           sel;
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    function automatic logic [W-1:0] sample(input int sel);
        case (sel)
            SEL_RD:  return rd_data;
            SEL_SP:  return W'(start_pulse);
            SEL_PP:  return W'(stop_pulse);
            SEL_RL:  return W'(release_pulse);
            default: return W'({cfg_ack_en, cfg_nostretch, cfg_gcall_en, cfg_pec_en,
                                cfg_arp_en, cfg_smb_host, cfg_smb_mode});
        endcase
    endfunction

    // monitor: compares all queued items away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [W-1:0] act;
                it  = sb.pop_front();
                act = sample(it.sel);
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input int sel, input logic [W-1:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // one clock: inputs were set before, settle after the edge, drop strobes
    task automatic step();
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        ev_start_sent = 1'b0; ev_stop_det = 1'b0; ev_timeout = 1'b0; ev_byte_done = 1'b0;
    endtask

    task automatic write(input logic [W-1:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        expect_val(SEL_RD, 10'h000, "R2 reset word");
        expect_val(SEL_SP, 0, "R11 reset start pulse");

        periph_en = 1'b1; master_mode = 1'b1; bus_free = 1'b1;
        write(10'h0FF);
        expect_val(SEL_RD, 10'h0FB, "R1 R2 cfg write, reserved ignored");
        expect_val(SEL_CFG, 10'h07F, "R2 cfg outputs");

        write(10'h0FB | M_START);
        expect_val(SEL_RD, 10'h1FB, "R7 start set");
        step();
        expect_val(SEL_SP, 1, "R7 master start pulse");
        step();
        expect_val(SEL_SP, 0, "R11 start pulse one cycle");
        expect_val(SEL_RD, 10'h1FB, "R11 start still pending");
        step();
        expect_val(SEL_SP, 0, "R11 no refire");

        write(10'h0FA | M_STOP);
        expect_val(SEL_RD, 10'h1FA, "R6 locked write");

        ev_start_sent = 1'b1; step();
        expect_val(SEL_RD, 10'h0FA, "R4 start cleared by start sent");

        ev_start_sent = 1'b1; write(10'h0FA | M_START);
        expect_val(SEL_RD, 10'h0FA, "R4 hw clear beats write");
        step();
        expect_val(SEL_SP, 0, "R4 no pulse after lost set");

        write(10'h0FA | M_STOP);
        expect_val(SEL_RD, 10'h2FA, "R5 stop set");
        ev_byte_done = 1'b1; step();
        expect_val(SEL_PP, 1, "R9 stop after byte");
        ev_byte_done = 1'b1; step();
        expect_val(SEL_PP, 0, "R11 stop once");
        ev_stop_det = 1'b1; step();
        expect_val(SEL_RD, 10'h0FA, "R5 stop cleared");

        write(10'h0FA | M_START | M_STOP);
        expect_val(SEL_RD, 10'h3FA, "R6 both requests set");
        step();
        expect_val(SEL_SP, 1, "R7 start pulse");
        expect_val(SEL_PP, 0, "R9 stop waits");
        ev_start_sent = 1'b1; step();
        expect_val(SEL_PP, 1, "R9 stop after start sent");
        expect_val(SEL_RD, 10'h2FA, "R4 start cleared");
        ev_stop_det = 1'b1; step();
        expect_val(SEL_RD, 10'h0FA, "R5 stop cleared");

        ev_timeout = 1'b1; step();
        expect_val(SEL_RD, 10'h2FA, "R5 timeout sets stop");
        ev_timeout = 1'b1; ev_stop_det = 1'b1; step();
        expect_val(SEL_RD, 10'h0FA, "R5 clear beats timeout");

        master_mode = 1'b0; bus_free = 1'b0;
        write(10'h0FA | M_START);
        step();
        expect_val(SEL_SP, 0, "R8 slave start waits");
        step();
        expect_val(SEL_SP, 0, "R8 still waiting");
        bus_free = 1'b1; step();
        expect_val(SEL_SP, 1, "R8 start on free bus");
        ev_start_sent = 1'b1; step();
        expect_val(SEL_RD, 10'h0FA, "R4 slave start cleared");

        write(10'h0FA | M_STOP);
        ev_byte_done = 1'b1; step();
        expect_val(SEL_RL, 1, "R10 release pulse");
        expect_val(SEL_PP, 0, "R10 no stop in slave");
        ev_stop_det = 1'b1; step();
        expect_val(SEL_RD, 10'h0FA, "R5 slave stop cleared");

        master_mode = 1'b1; periph_en = 1'b0;
        write(10'h0FA | M_START);
        expect_val(SEL_RD, 10'h07A, "R3 R4 disabled clears ack and start");
        step();
        expect_val(SEL_SP, 0, "R4 no start while disabled");
        write(10'h0FA);
        expect_val(SEL_RD, 10'h07A, "R3 ack write lost while disabled");
        periph_en = 1'b1;
        write(10'h0FA);
        expect_val(SEL_RD, 10'h0FA, "R3 ack written when enabled");

        @(negedge clk);
        @(posedge clk);
        #1;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule